// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block brings one switchable logic domain up or down by walking a fixed list of control steps. The steps drive the domain's power switch, its memory bank power-down fields, its isolation clamp, its local reset and its clock enable. The two directions use different orders. Settle delays separate the steps. The delays are counted in ticks of a 1 µs reference strobe. The block owns no switch or memory itself; it only drives the control lines that feed them.

A requester raises a level on `req_on` or `req_off` and holds it until `ack_o` pulses. The block samples requests only while idle. It runs the whole sequence, pulses `ack_o` for one cycle and goes back to idle. Three build options say whether the domain has a top-level switch, a local reset and a gated clock. When an option is absent, its steps are dropped and its output keeps its reset value. `pwr_off_o` reports the domain's state as the level of the switch sleep line.

States: IDLE; down path DN_SLEEP, DN_SETTLE_A, DN_MEM, DN_SETTLE_B, DN_ISO, DN_HOLD, DN_CLK; up path UP_SLEEP, UP_SETTLE_A, UP_MEM, UP_SETTLE_B, UP_RST_ON, UP_ISO, UP_RST_OFF, UP_CLK; then ACK. Transitions:
- IDLE goes to DN_SLEEP on `req_off`, otherwise to UP_SLEEP on `req_on`.
- Each action state loads the tick timer when a wait follows it.
- A settle state moves on once the timer reaches zero.
- DN_ISO goes to DN_HOLD when a clock is present, otherwise to ACK.
- UP_SETTLE_B goes to UP_RST_ON when a reset is present, otherwise to UP_ISO.
- UP_ISO goes to UP_RST_OFF, else UP_CLK, else ACK, by the options present. UP_RST_OFF goes to UP_CLK or ACK.
- ACK always returns to IDLE.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the outputs read: sleep_o=1, iso_o=1, every mem_pd_o bit 1, dom_rst_o=1, clk_en_o=0, ack_o=0, pwr_off_o=1.
- R2: Power-down order. Raise sleep, wait SHORT_WAIT ticks, set every memory field to all ones, wait SHORT_WAIT ticks, raise isolation, wait LONG_WAIT ticks, drop the clock enable, then acknowledge.
- R3: Power-up order. Drop sleep, wait SHORT_WAIT ticks, clear every memory field to zero, wait SHORT_WAIT ticks, assert the domain reset, release isolation, release the reset, raise the clock enable, then acknowledge.
- R4: Without a top-level switch, sleep_o and iso_o never move. Both SHORT_WAIT waits and the memory step are still performed.
- R5: Without a reset option, dom_rst_o never moves. Without a clock option, clk_en_o never moves and the LONG_WAIT wait is skipped.
- R6: mem_pd_o is NUM_BANKS fields of BANK_W bits each. All fields change in the same cycle and are always either all ones (banks off) or all zeros (banks on).
- R7: pwr_off_o always equals sleep_o.
- R8: A request seen while a sequence runs is not taken up. The sequence in progress completes unchanged. ack_o is high for exactly one cycle, and the block is idle in the cycle after.
- R9: A request for the state the domain already has still runs its full sequence, with all its waits, and acknowledges.
- R10: When req_on and req_off are both high in an idle cycle, the power-down sequence runs.
- R11: With a switch present, isolation is released only while the memory fields are zero and sleep is low. Reset release and clock enable rise only while isolation is released. Isolation is high whenever the clock enable falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe every microsecond; wait timers count these |
| req_on | input | 1 | Power-up request level, held until ack |
| req_off | input | 1 | Power-down request level, held until ack |
| ack_o | output | 1 | One-cycle pulse when a sequence completes |
| sleep_o | output | 1 | Power-switch sleep control, 1 = switch open |
| iso_o | output | 1 | Isolation clamp control, 1 = clamped |
| mem_pd_o | output | NUM_BANKS*BANK_W | Memory bank power-down fields, all ones = banks off |
| dom_rst_o | output | 1 | Domain reset, 1 = held in reset |
| clk_en_o | output | 1 | Domain clock enable |
| pwr_off_o | output | 1 | Power state, 1 = domain off |

## Verification
Two things can fall in the same cycle: a request arriving and a sequence finishing or being accepted. The bench raises `req_on` in the middle of a power-down wait and holds it through the ack cycle. It then checks that the down sequence is logged unchanged and that nothing starts afterwards. In a separate case it raises both requests in one idle cycle and expects a power-down whose only logged event is the acknowledge, reached after 2*SHORT_WAIT+LONG_WAIT ticks. Every output edge is logged with its tick stamp. The log is then compared with an order and spacing worked out from the wait parameters, on a fully optioned domain and on one with no switch, reset or clock.

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
    typedef enum logic [4:0] {
        ST_IDLE,
        ST_DN_SLEEP,
        ST_DN_SETTLE_A,
        ST_DN_MEM,
        ST_DN_SETTLE_B,
        ST_DN_ISO,
        ST_DN_HOLD,
        ST_DN_CLK,
        ST_UP_SLEEP,
        ST_UP_SETTLE_A,
        ST_UP_MEM,
        ST_UP_SETTLE_B,
        ST_UP_RST_ON,
        ST_UP_ISO,
        ST_UP_RST_OFF,
        ST_UP_CLK,
        ST_ACK
    } pgs_state_e;
endpackage

// File: rtl/pgs_timer.sv
`timescale 1ns/1ps
// Down-counter of reference ticks; a load wins over a tick in the same cycle.
module pgs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgs_memfield.sv
`timescale 1ns/1ps
// Fans one bank-off level out to every memory power-down field.
module pgs_memfield #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    localparam int MEM_W    = NUM_BANKS * BANK_W
) (
    input  logic             banks_off,
    output logic [MEM_W-1:0] fields
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign fields[b*BANK_W +: BANK_W] = {BANK_W{banks_off}};
    end
endmodule

// File: rtl/pwr_gate_seq.sv
`timescale 1ns/1ps
module pwr_gate_seq #(
    parameter int NUM_BANKS  = 4,
    parameter int BANK_W     = 2,
    parameter int SHORT_WAIT = 20,
    parameter int LONG_WAIT  = 20000,
    parameter bit HAS_SWITCH = 1'b1,
    parameter bit HAS_RESET  = 1'b1,
    parameter bit HAS_CLOCK  = 1'b1,
    localparam int MEM_W     = NUM_BANKS * BANK_W,
    localparam int MAX_WAIT  = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT,
    localparam int CNT_W     = $clog2(MAX_WAIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             req_on,
    input  logic             req_off,
    output logic             ack_o,
    output logic             sleep_o,
    output logic             iso_o,
    output logic [MEM_W-1:0] mem_pd_o,
    output logic             dom_rst_o,
    output logic             clk_en_o,
    output logic             pwr_off_o
);
    import pgs_pkg::*;

    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT);

    pgs_state_e       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    logic sleep_q, iso_q, banks_off_q, rst_q, cen_q;

    pgs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick_us),
        .expired  (tmr_done)
    );

    pgs_memfield #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_memfield (
        .banks_off (banks_off_q),
        .fields    (mem_pd_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = SHORT_LD;
        unique case (state_q)
            ST_IDLE: begin
                if (req_off)     state_d = ST_DN_SLEEP;
                else if (req_on) state_d = ST_UP_SLEEP;
            end
            ST_DN_SLEEP: begin
                tmr_load = 1'b1;
                state_d  = ST_DN_SETTLE_A;
            end
            ST_DN_SETTLE_A: if (tmr_done) state_d = ST_DN_MEM;
            ST_DN_MEM: begin
                tmr_load = 1'b1;
                state_d  = ST_DN_SETTLE_B;
            end
            ST_DN_SETTLE_B: if (tmr_done) state_d = ST_DN_ISO;
            ST_DN_ISO: begin
                if (HAS_CLOCK) begin
                    tmr_load = 1'b1;
                    tmr_val  = LONG_LD;
                    state_d  = ST_DN_HOLD;
                end else begin
                    state_d  = ST_ACK;
                end
            end
            ST_DN_HOLD: if (tmr_done) state_d = ST_DN_CLK;
            ST_DN_CLK:  state_d = ST_ACK;
            ST_UP_SLEEP: begin
                tmr_load = 1'b1;
                state_d  = ST_UP_SETTLE_A;
            end
            ST_UP_SETTLE_A: if (tmr_done) state_d = ST_UP_MEM;
            ST_UP_MEM: begin
                tmr_load = 1'b1;
                state_d  = ST_UP_SETTLE_B;
            end
            ST_UP_SETTLE_B: begin
                if (tmr_done) state_d = HAS_RESET ? ST_UP_RST_ON : ST_UP_ISO;
            end
            ST_UP_RST_ON: state_d = ST_UP_ISO;
            ST_UP_ISO: begin
                if (HAS_RESET)      state_d = ST_UP_RST_OFF;
                else if (HAS_CLOCK) state_d = ST_UP_CLK;
                else                state_d = ST_ACK;
            end
            ST_UP_RST_OFF: state_d = HAS_CLOCK ? ST_UP_CLK : ST_ACK;
            ST_UP_CLK:     state_d = ST_ACK;
            ST_ACK:        state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Control outputs, each step changing its line as the state is left
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q     <= 1'b1;
            iso_q       <= 1'b1;
            banks_off_q <= 1'b1;
            rst_q       <= 1'b1;
            cen_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DN_SLEEP:   if (HAS_SWITCH) sleep_q <= 1'b1;
                ST_DN_MEM:     banks_off_q <= 1'b1;
                ST_DN_ISO:     if (HAS_SWITCH) iso_q <= 1'b1;
                ST_DN_CLK:     if (HAS_CLOCK) cen_q <= 1'b0;
                ST_UP_SLEEP:   if (HAS_SWITCH) sleep_q <= 1'b0;
                ST_UP_MEM:     banks_off_q <= 1'b0;
                ST_UP_RST_ON:  if (HAS_RESET) rst_q <= 1'b1;
                ST_UP_ISO:     if (HAS_SWITCH) iso_q <= 1'b0;
                ST_UP_RST_OFF: if (HAS_RESET) rst_q <= 1'b0;
                ST_UP_CLK:     if (HAS_CLOCK) cen_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign ack_o     = (state_q == ST_ACK);
    assign sleep_o   = sleep_q;
    assign iso_o     = iso_q;
    assign dom_rst_o = rst_q;
    assign clk_en_o  = cen_q;
    assign pwr_off_o = sleep_q;
endmodule

// File: rtl/pwr_gate_seq_chk.sv
`timescale 1ns/1ps
module pwr_gate_seq_chk #(
    parameter int MEM_W      = 8,
    parameter bit HAS_SWITCH = 1'b1,
    parameter bit HAS_RESET  = 1'b1,
    parameter bit HAS_CLOCK  = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_o,
    input logic             sleep_o,
    input logic             iso_o,
    input logic [MEM_W-1:0] mem_pd_o,
    input logic             dom_rst_o,
    input logic             clk_en_o
);
    // R8: acknowledge lasts one cycle
    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    if (HAS_SWITCH) begin : g_sw
        // R2: isolation clamps only after every bank is off
        a_r2_iso_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(iso_o) |-> (&mem_pd_o));
        // R11: isolation released only with banks on and switch closed
        a_r11_iso_release: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(iso_o) |-> ((mem_pd_o == '0) && !sleep_o));
        // R11: reset release needs isolation released
        a_r11_rst_release: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dom_rst_o) |-> !iso_o);
        // R11: clock starts only with isolation released
        a_r11_clk_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_en_o) |-> !iso_o);
        // R11: clock stops only while isolated
        a_r11_clk_stop: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clk_en_o) |-> iso_o);
    end else begin : g_nosw
        // R4: switch and isolation lines never move
        a_r4_lines_still: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(sleep_o) && $stable(iso_o));
    end

    if (!HAS_RESET) begin : g_norst
        // R5: no reset option, reset line never moves
        a_r5_rst_still: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(dom_rst_o));
    end

    if (!HAS_CLOCK) begin : g_noclk
        // R5: no clock option, enable never moves
        a_r5_clk_still: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(clk_en_o));
    end
endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(
    .MEM_W      (NUM_BANKS * BANK_W),
    .HAS_SWITCH (HAS_SWITCH),
    .HAS_RESET  (HAS_RESET),
    .HAS_CLOCK  (HAS_CLOCK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_o     (ack_o),
    .sleep_o   (sleep_o),
    .iso_o     (iso_o),
    .mem_pd_o  (mem_pd_o),
    .dom_rst_o (dom_rst_o),
    .clk_en_o  (clk_en_o)
);

// File: tb/pwr_gate_seq_tb.sv
`timescale 1ns/1ps
// Records every output edge of one sequencer with the tick count at that edge.
module pwr_gate_seq_log #(
    parameter int MEM_W = 8
) (
    input logic             clk,
    input logic             clr,
    input int               tstamp,
    input logic             sleep,
    input logic             iso,
    input logic [MEM_W-1:0] mem,
    input logic             rst,
    input logic             cen,
    input logic             ack
);
    int codes [32];
    int stamps[32];
    int n;
    logic p_sleep, p_iso, p_rst, p_cen;
    logic [MEM_W-1:0] p_mem;

    initial n = 0;

    function automatic void push(int c);
        if (n < 32) begin
            codes[n]  = c;
            stamps[n] = tstamp;
        end
        n = n + 1;
    endfunction

    always @(negedge clk) begin
        if (clr) begin
            n = 0;
        end else begin
            if (sleep !== p_sleep) push(sleep ? 1 : 2);
            if (mem !== p_mem) push((mem == '1) ? 3 : ((mem == '0) ? 4 : 12));
            if (rst !== p_rst) push(rst ? 7 : 8);
            if (iso !== p_iso) push(iso ? 5 : 6);
            if (cen !== p_cen) push(cen ? 9 : 10);
            if (ack) push(11);
        end
        p_sleep = sleep;
        p_iso   = iso;
        p_mem   = mem;
        p_rst   = rst;
        p_cen   = cen;
    end
endmodule

module pwr_gate_seq_tb;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int MW = NB * BW;
    localparam int SW = 6;
    localparam int LW = 40;

    localparam int E_SLP_R = 1, E_SLP_F = 2, E_MEM_OFF = 3, E_MEM_ON = 4;
    localparam int E_ISO_R = 5, E_ISO_F = 6, E_RST_R = 7, E_RST_F = 8;
    localparam int E_CLK_R = 9, E_CLK_F = 10, E_ACK = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic clr = 1'b0;
    logic ron = 1'b0, roff = 1'b0, ron2 = 1'b0, roff2 = 1'b0;
    int   tick_cnt = 0;
    int   phase = 0;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    logic          ack, slp, iso, rst, cen, poff;
    logic [MW-1:0] mem;
    logic          ack2, slp2, iso2, rst2, cen2, poff2;
    logic [MW-1:0] mem2;

    always #10 clk = ~clk;

    pwr_gate_seq #(.NUM_BANKS(NB), .BANK_W(BW), .SHORT_WAIT(SW), .LONG_WAIT(LW),
        .HAS_SWITCH(1'b1), .HAS_RESET(1'b1), .HAS_CLOCK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .req_on(ron), .req_off(roff),
        .ack_o(ack), .sleep_o(slp), .iso_o(iso), .mem_pd_o(mem),
        .dom_rst_o(rst), .clk_en_o(cen), .pwr_off_o(poff));

    pwr_gate_seq #(.NUM_BANKS(NB), .BANK_W(BW), .SHORT_WAIT(SW), .LONG_WAIT(LW),
        .HAS_SWITCH(1'b0), .HAS_RESET(1'b0), .HAS_CLOCK(1'b0)) u_min (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .req_on(ron2), .req_off(roff2),
        .ack_o(ack2), .sleep_o(slp2), .iso_o(iso2), .mem_pd_o(mem2),
        .dom_rst_o(rst2), .clk_en_o(cen2), .pwr_off_o(poff2));

    pwr_gate_seq_log #(.MEM_W(MW)) u_log (.clk(clk), .clr(clr), .tstamp(tick_cnt),
        .sleep(slp), .iso(iso), .mem(mem), .rst(rst), .cen(cen), .ack(ack));
    pwr_gate_seq_log #(.MEM_W(MW)) u_log2 (.clk(clk), .clr(clr), .tstamp(tick_cnt),
        .sleep(slp2), .iso(iso2), .mem(mem2), .rst(rst2), .cen(cen2), .ack(ack2));

    // Tick strobe every fifth cycle, counted at the edge that samples it
    always @(negedge clk) begin
        phase <= (phase == 4) ? 0 : phase + 1;
        tick  <= (phase == 4);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tick) tick_cnt <= tick_cnt + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int lg_code(int sel, int i);
        return sel ? u_log2.codes[i] : u_log.codes[i];
    endfunction
    function automatic int lg_stamp(int sel, int i);
        return sel ? u_log2.stamps[i] : u_log.stamps[i];
    endfunction
    function automatic int lg_n(int sel);
        return sel ? u_log2.n : u_log.n;
    endfunction

    task automatic chk_val(string rq, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_n(int sel, string rq, int exp);
        chk_val(rq, "event count", lg_n(sel), exp);
    endtask

    // Event idx must carry code and lie d..d+tol ticks after the previous one
    task automatic chk_evt(int sel, string rq, int idx, int code, int d, int tol, int base);
        int dl;
        int cd;
        cd = lg_code(sel, idx);
        dl = lg_stamp(sel, idx) - ((idx == 0) ? base : lg_stamp(sel, idx - 1));
        total++;
        if (cd != code || dl < d || dl > d + tol) begin
            bad++;
            $display("FAIL %s event %0d: actual code=%0d delta=%0d expected code=%0d delta=%0d..%0d",
                     rq, idx, cd, dl, code, d, d + tol);
        end
    endtask

    // Clear logs, raise a request, wait for ack, drop the request
    task automatic run_req(int sel, bit on, bit off, output int base);
        int waited;
        @(posedge clk) clr <= 1'b1;
        @(posedge clk) clr <= 1'b0;
        @(negedge clk);
        base = tick_cnt;
        if (sel == 0) begin ron = on;  roff = off;  end
        else          begin ron2 = on; roff2 = off; end
        waited = 0;
        while (((sel == 0) ? ack : ack2) !== 1'b1 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        chk_val("R8", "ack seen", int'(waited < 5000), 1);
        ron = 1'b0; roff = 1'b0; ron2 = 1'b0; roff2 = 1'b0;
        @(negedge clk);
        chk_val("R8", "ack width", int'((sel == 0) ? ack : ack2), 0);
        @(negedge clk);
    endtask

    initial begin
        int b;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state on both builds
        chk_val("R1", "sleep", int'(slp), 1);
        chk_val("R1", "iso", int'(iso), 1);
        chk_val("R1", "mem", int'(mem == '1), 1);
        chk_val("R1", "rst", int'(rst), 1);
        chk_val("R1", "clk_en", int'(cen), 0);
        chk_val("R1", "ack", int'(ack), 0);
        chk_val("R1", "pwr_off", int'(poff), 1);
        chk_val("R1", "min mem", int'(mem2 == '1), 1);

        // R3 first power-up: reset already asserted, so no reset rise event
        run_req(0, 1'b1, 1'b0, b);
        chk_n(0, "R3", 6);
        chk_evt(0, "R3", 0, E_SLP_F, 0, 3, b);
        chk_evt(0, "R3", 1, E_MEM_ON, SW, 1, b);
        chk_evt(0, "R3", 2, E_ISO_F, SW, 1, b);
        chk_evt(0, "R3", 3, E_RST_F, 0, 1, b);
        chk_evt(0, "R3", 4, E_CLK_R, 0, 1, b);
        chk_evt(0, "R3", 5, E_ACK, 0, 1, b);
        chk_val("R7", "pwr_off after up", int'(poff), int'(slp));
        chk_val("R7", "pwr_off on", int'(poff), 0);

        // R9 redundant power-up: only the reset pulse is visible
        run_req(0, 1'b1, 1'b0, b);
        chk_n(0, "R9", 3);
        chk_evt(0, "R9", 0, E_RST_R, 2 * SW, 3, b);
        chk_evt(0, "R9", 1, E_RST_F, 0, 1, b);
        chk_evt(0, "R9", 2, E_ACK, 0, 1, b);

        // R2 power-down, R6 fields move together as all ones
        run_req(0, 1'b0, 1'b1, b);
        chk_n(0, "R2", 5);
        chk_evt(0, "R2", 0, E_SLP_R, 0, 3, b);
        chk_evt(0, "R6", 1, E_MEM_OFF, SW, 1, b);
        chk_evt(0, "R2", 2, E_ISO_R, SW, 1, b);
        chk_evt(0, "R2", 3, E_CLK_F, LW, 1, b);
        chk_evt(0, "R2", 4, E_ACK, 0, 1, b);
        chk_val("R7", "pwr_off off", int'(poff), 1);

        // R3 power-up from a released reset: full step list
        run_req(0, 1'b1, 1'b0, b);
        chk_n(0, "R3", 7);
        chk_evt(0, "R3", 0, E_SLP_F, 0, 3, b);
        chk_evt(0, "R6", 1, E_MEM_ON, SW, 1, b);
        chk_evt(0, "R3", 2, E_RST_R, SW, 1, b);
        chk_evt(0, "R3", 3, E_ISO_F, 0, 1, b);
        chk_evt(0, "R3", 4, E_RST_F, 0, 1, b);
        chk_evt(0, "R3", 5, E_CLK_R, 0, 1, b);
        chk_evt(0, "R3", 6, E_ACK, 0, 1, b);

        // R8 a power-up request raised mid power-down is not taken up
        @(posedge clk) clr <= 1'b1;
        @(posedge clk) clr <= 1'b0;
        @(negedge clk);
        b = tick_cnt;
        roff = 1'b1;
        repeat (20) @(negedge clk);
        ron = 1'b1;
        n0 = 0;
        while (ack !== 1'b1 && n0 < 5000) begin
            @(negedge clk);
            n0++;
        end
        ron = 1'b0; roff = 1'b0;
        repeat (SW * 5 * 3) @(negedge clk);
        chk_n(0, "R8", 5);
        chk_evt(0, "R8", 0, E_SLP_R, 0, 3, b);
        chk_evt(0, "R8", 1, E_MEM_OFF, SW, 1, b);
        chk_evt(0, "R8", 2, E_ISO_R, SW, 1, b);
        chk_evt(0, "R8", 3, E_CLK_F, LW, 1, b);
        chk_evt(0, "R8", 4, E_ACK, 0, 1, b);
        chk_val("R8", "stays off", int'(poff), 1);

        // R10 both requests in one idle cycle: down wins; R9 no line changes
        run_req(0, 1'b1, 1'b1, b);
        chk_n(0, "R10", 1);
        chk_evt(0, "R10", 0, E_ACK, 2 * SW + LW, 3, b);
        chk_val("R10", "pwr_off", int'(poff), 1);
        chk_val("R10", "clk_en", int'(cen), 0);

        // R4 R5 minimal build: only memory step and both short waits
        run_req(1, 1'b1, 1'b0, b);
        chk_n(1, "R4", 2);
        chk_evt(1, "R4", 0, E_MEM_ON, SW, 3, b);
        chk_evt(1, "R4", 1, E_ACK, SW, 1, b);
        chk_val("R4", "min sleep", int'(slp2), 1);
        chk_val("R4", "min iso", int'(iso2), 1);
        chk_val("R7", "min pwr_off", int'(poff2), int'(slp2));
        run_req(1, 1'b0, 1'b1, b);
        chk_n(1, "R5", 2);
        chk_evt(1, "R6", 0, E_MEM_OFF, SW, 3, b);
        chk_evt(1, "R5", 1, E_ACK, SW, 1, b);
        chk_val("R5", "min rst", int'(rst2), 1);
        chk_val("R5", "min clk_en", int'(cen2), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule